// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words, A and B, and raises exactly one of three result lines: A greater than B, A equal to B, or A less than B. It is built from identical fixed-width slices. Each slice compares its own bit pairs starting from the most significant pair. The first pair that differs settles the slice result. Only when every local pair matches does the slice pass through the result supplied on its three cascade inputs.

The top level chains as many slices as it needs to cover the word width. The default is a 7-bit compare made from two 4-bit slices. Each slice's results drive the cascade inputs of the slice above it. The spare bit positions at the top of the upper slice are tied to equal constants, so they never decide the result. The chain's own cascade inputs are brought out, which lets a wider comparator use this block as one of its stages. When this block is the least significant stage, its equal cascade input is held at 1 and the other two at 0. A parameter selects the internal prefix structure: a serial scan from the most significant bit, or a flat form in which every bit position is decided in parallel.

Top module: `mag_cmp_cascade`

## Requirements
- R1: With cascade inputs (gt,eq,lt) = (0,1,0), `a_gt_b` is 1 exactly when `a_word` > `b_word` as unsigned numbers.
- R2: With cascade inputs (0,1,0), `a_lt_b` is 1 exactly when `a_word` < `b_word` as unsigned numbers.
- R3: With cascade inputs (0,1,0), `a_eq_b` is 1 exactly when `a_word` == `b_word`.
- R4: Whenever exactly one cascade input is 1, exactly one of the three outputs is 1.
- R5: The most significant differing bit pair decides the result, whatever the lower bits and the cascade inputs are. For example, A=7'h40 and B=7'h3F give greater with cascade input (0,0,1).
- R6: When `a_word` equals `b_word`, the outputs (gt,eq,lt) copy the cascade inputs bit for bit, for all eight cascade patterns, including patterns that are not one-hot.
- R7: When bits 6..4 of the two words match, bits 3..0 decide the result, and that result crosses the boundary between the lower and upper slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | 7 | Operand A, unsigned |
| b_word | input | 7 | Operand B, unsigned |
| cin_gt | input | 1 | Cascade "greater" from a less significant stage (tie to 0 when unused) |
| cin_eq | input | 1 | Cascade "equal" from a less significant stage (tie to 1 when unused) |
| cin_lt | input | 1 | Cascade "less" from a less significant stage (tie to 0 when unused) |
| a_gt_b | output | 1 | A is greater than B |
| a_eq_b | output | 1 | A equals B (or copies the cascade when all bits match) |
| a_lt_b | output | 1 | A is less than B |

## Verification
All three results are purely combinational, so each one is due in the same cycle as the operands and cascade pattern that produce it, with no register on the path. The driver changes inputs on the falling clock edge and queues the expected flags. The monitor pops and compares on the following rising edge, half a period after the inputs settle and before the next change. The full 128 by 128 operand space is swept with the least-significant cascade tie-off. The equal-word pass-through, the most-significant-bit priority and the crossing at the slice boundary are driven as separate patterns.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cmp_flags_t;

   typedef enum logic [0:0] {
      SCAN_SERIAL = 1'b0,
      SCAN_FLAT   = 1'b1
   } scan_style_t;

   localparam cmp_flags_t CMP_TIE_LSB = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

   function automatic int unsigned slices_needed(int unsigned total_w, int unsigned slice_w);
      return (total_w + slice_w - 1) / slice_w;
   endfunction

endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell
   import cmp_pkg::*;
(
   input  logic       a_bit,
   input  logic       b_bit,
   output cmp_flags_t rel
);

   always_comb begin
      rel.gt = a_bit & ~b_bit;
      rel.lt = ~a_bit & b_bit;
      rel.eq = ~(a_bit ^ b_bit);
   end

   always_comb begin
      if (!$isunknown({a_bit, b_bit})) begin
         AST_BIT_ONE_HOT: assert ($onehot({rel.gt, rel.eq, rel.lt})); // R4
      end
   end

endmodule

// File: rtl/cmp_prefix.sv
module cmp_prefix
   import cmp_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter scan_style_t STYLE = SCAN_FLAT
)(
   input  logic [WIDTH-1:0] bit_gt,
   input  logic [WIDTH-1:0] bit_eq,
   input  logic [WIDTH-1:0] bit_lt,
   output logic             any_gt,
   output logic             any_lt,
   output logic             all_eq
);

   initial begin
      AST_PREFIX_WIDTH: assert (WIDTH >= 1); // R7
   end

   generate
      if (STYLE == SCAN_SERIAL) begin : g_serial
         always_comb begin
            any_gt = 1'b0;
            any_lt = 1'b0;
            all_eq = 1'b1;
            for (int i = WIDTH - 1; i >= 0; i--) begin
               if (all_eq) begin
                  any_gt = bit_gt[i];
                  any_lt = bit_lt[i];
               end
               all_eq = all_eq & bit_eq[i];
            end
         end
      end else begin : g_flat
         logic [WIDTH-1:0] upper_match;
         for (genvar i = 0; i < WIDTH; i++) begin : g_pos
            if (i == WIDTH - 1) begin : g_top
               assign upper_match[i] = 1'b1;
            end else begin : g_low
               assign upper_match[i] = &bit_eq[WIDTH-1:i+1];
            end
         end
         assign any_gt = |(bit_gt & upper_match);
         assign any_lt = |(bit_lt & upper_match);
         assign all_eq = &bit_eq;
      end
   endgenerate

   always_comb begin
      if (!$isunknown({bit_gt, bit_eq, bit_lt})) begin
         AST_PREFIX_EXCLUSIVE: assert ($countones({any_gt, any_lt, all_eq}) == 1); // R4
      end
   end

endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
   import cmp_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter scan_style_t STYLE = SCAN_FLAT
)(
   input  logic [WIDTH-1:0] a_part,
   input  logic [WIDTH-1:0] b_part,
   input  cmp_flags_t       casc_in,
   output cmp_flags_t       casc_out
);

   logic [WIDTH-1:0] bit_gt, bit_eq, bit_lt;
   logic             any_gt, any_lt, all_eq;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      cmp_flags_t cell_rel;
      cmp_bit_cell u_cell (
         .a_bit (a_part[i]),
         .b_bit (b_part[i]),
         .rel   (cell_rel)
      );
      assign bit_gt[i] = cell_rel.gt;
      assign bit_eq[i] = cell_rel.eq;
      assign bit_lt[i] = cell_rel.lt;
   end

   cmp_prefix #(.WIDTH(WIDTH), .STYLE(STYLE)) u_prefix (
      .bit_gt (bit_gt),
      .bit_eq (bit_eq),
      .bit_lt (bit_lt),
      .any_gt (any_gt),
      .any_lt (any_lt),
      .all_eq (all_eq)
   );

   always_comb begin
      casc_out.gt = any_gt | (all_eq & casc_in.gt);
      casc_out.eq = all_eq & casc_in.eq;
      casc_out.lt = any_lt | (all_eq & casc_in.lt);
   end

   always_comb begin
      if (!$isunknown({a_part, b_part, casc_in})) begin
         if (a_part == b_part) begin
            AST_SLICE_PASS: assert (casc_out == casc_in); // R6
         end
         if (a_part != b_part) begin
            AST_SLICE_LOCAL: assert (casc_out.gt == (a_part > b_part) && !casc_out.eq); // R5
         end
         if ($onehot(casc_in)) begin
            AST_SLICE_ONE_HOT: assert ($onehot(casc_out)); // R4
         end
      end
   end

endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade
   import cmp_pkg::*;
#(
   parameter int unsigned TOTAL_W = 7,
   parameter int unsigned SLICE_W = 4,
   parameter scan_style_t STYLE   = SCAN_FLAT
)(
   input  logic [TOTAL_W-1:0] a_word,
   input  logic [TOTAL_W-1:0] b_word,
   input  logic               cin_gt,
   input  logic               cin_eq,
   input  logic               cin_lt,
   output logic               a_gt_b,
   output logic               a_eq_b,
   output logic               a_lt_b
);

   localparam int unsigned N_SLICES = slices_needed(TOTAL_W, SLICE_W);
   localparam int unsigned FULL_W   = N_SLICES * SLICE_W;

   initial begin
      AST_TOTAL_WIDTH: assert (TOTAL_W >= 1); // R1
      AST_SLICE_WIDTH: assert (SLICE_W >= 1 && SLICE_W <= 16); // R7
   end

   // Spare top positions are zero on both sides, so they always compare equal.
   logic [FULL_W-1:0] a_pad, b_pad;
   assign a_pad = FULL_W'(a_word);
   assign b_pad = FULL_W'(b_word);

   cmp_flags_t link [N_SLICES+1];
   assign link[0] = '{gt: cin_gt, eq: cin_eq, lt: cin_lt};

   for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
      cmp_slice #(.WIDTH(SLICE_W), .STYLE(STYLE)) u_slice (
         .a_part   (a_pad[k*SLICE_W +: SLICE_W]),
         .b_part   (b_pad[k*SLICE_W +: SLICE_W]),
         .casc_in  (link[k]),
         .casc_out (link[k+1])
      );
   end

   assign a_gt_b = link[N_SLICES].gt;
   assign a_eq_b = link[N_SLICES].eq;
   assign a_lt_b = link[N_SLICES].lt;

   always_comb begin
      if (!$isunknown({a_word, b_word, cin_gt, cin_eq, cin_lt})) begin
         if ({cin_gt, cin_eq, cin_lt} == 3'b010) begin
            AST_GT_MATCH: assert (a_gt_b == (a_word > b_word)); // R1
            AST_LT_MATCH: assert (a_lt_b == (a_word < b_word)); // R2
            AST_EQ_MATCH: assert (a_eq_b == (a_word == b_word)); // R3
         end
         if (a_word == b_word) begin
            AST_EQ_COPY: assert ({a_gt_b, a_eq_b, a_lt_b} == {cin_gt, cin_eq, cin_lt}); // R6
         end
      end
   end

endmodule

// File: tb/test_mag_cmp_cascade.sv
module test_mag_cmp_cascade;

   logic       clk = 1'b0;
   logic [6:0] a_word = '0, b_word = '0;
   logic       cin_gt = 1'b0, cin_eq = 1'b1, cin_lt = 1'b0;
   logic       a_gt_b, a_eq_b, a_lt_b;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [2:0] exp;
      string      req;
      logic [6:0] a;
      logic [6:0] b;
   } sb_item_t;

   sb_item_t sb_q[$];

   always #5 clk = ~clk;

   mag_cmp_cascade i_mag_cmp_cascade (
      .a_word (a_word),
      .b_word (b_word),
      .cin_gt (cin_gt),
      .cin_eq (cin_eq),
      .cin_lt (cin_lt),
      .a_gt_b (a_gt_b),
      .a_eq_b (a_eq_b),
      .a_lt_b (a_lt_b)
   );

   // Driver: inputs change on the falling edge; the result is due with no latency.
   task automatic drive(input logic [6:0] a, input logic [6:0] b,
                        input logic [2:0] cin, input logic [2:0] exp, input string req);
      sb_item_t it;
      @(negedge clk);
      a_word = a;
      b_word = b;
      {cin_gt, cin_eq, cin_lt} = cin;
      it.exp = exp; it.req = req; it.a = a; it.b = b;
      sb_q.push_back(it);
   endtask

   function automatic logic [2:0] rel(input logic [6:0] a, input logic [6:0] b,
                                      input logic [2:0] cin);
      if (a > b)      return 3'b100;
      else if (a < b) return 3'b001;
      else            return cin;
   endfunction

   // Monitor: compares on the rising edge, half a period after the inputs change.
   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         logic [2:0] act;
         it  = sb_q.pop_front();
         act = {a_gt_b, a_eq_b, a_lt_b};
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h actual=%b expected=%b", it.req, it.a, it.b, act, it.exp);
         end
      end
   end

   initial begin
      // Initial state with zero operands and the tie-off: equal (R3)
      drive(7'h00, 7'h00, 3'b010, 3'b010, "R3");

      // Exhaustive sweep against the relational operators (R1 R2 R3)
      for (int a = 0; a < 128; a++) begin
         for (int b = 0; b < 128; b++) begin
            drive(7'(a), 7'(b), 3'b010, rel(7'(a), 7'(b), 3'b010),
                  (a > b) ? "R1" : ((a < b) ? "R2" : "R3"));
         end
      end

      // One-hot outputs under the other one-hot cascade patterns (R4)
      for (int a = 0; a < 128; a += 5) begin
         for (int b = 0; b < 128; b += 3) begin
            drive(7'(a), 7'(b), 3'b100, rel(7'(a), 7'(b), 3'b100), "R4");
            drive(7'(a), 7'(b), 3'b001, rel(7'(a), 7'(b), 3'b001), "R4");
         end
      end

      // The most significant differing pair wins over lower bits and the cascade (R5)
      drive(7'h40, 7'h3F, 3'b001, 3'b100, "R5");
      drive(7'h3F, 7'h40, 3'b100, 3'b001, "R5");
      drive(7'h08, 7'h07, 3'b001, 3'b100, "R5");

      // Equal words copy all eight cascade patterns (R6)
      for (int c = 0; c < 8; c++) begin
         drive(7'h55, 7'h55, 3'(c), 3'(c), "R6");
         drive(7'h7F, 7'h7F, 3'(c), 3'(c), "R6");
      end

      // Upper bits equal: lower slice decides across the boundary (R7)
      drive(7'h25, 7'h23, 3'b001, 3'b100, "R7");
      drive(7'h21, 7'h2E, 3'b100, 3'b001, "R7");
      drive(7'h70, 7'h70, 3'b001, 3'b001, "R7");

      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 200000) begin
         @(posedge clk);
         cyc++;
      end
      #1;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule